// File: doc/BRIEF.md
# Memory Chip-Enable Guard with Power-Fail Lockout

This block stands between a host's active-low chip enable and an external memory device that shares its address space with a serial timekeeping register port. Under a good supply the memory enable follows the host enable with no register in the path. While the serial port has its transfer window open, the memory is kept deselected so that the host's cycles reach only the timekeeping registers.

When the digital power-fail indication is high, the memory enable is forced at once to a level that depends on the attached device. A RAM is deselected so that it is write-protected. A ROM is held enabled low, because it keeps its contents without power. The block also drives two control signals for the serial port. `abort` tells it to drop any transfer in progress and to clear its key pointer and bit counter, leaving the time registers untouched. `lockout` blocks any new access until the supply has recovered. A separate active-low reset pin, passed through a synchronizer, can also raise `abort` unless the reset-ignore register bit is set.

The controller is a four-state machine:
- `ST_RUN`: normal operation.
- `ST_PINRST`: abort requested by the reset pin.
- `ST_FAIL`: power failure; abort and lockout.
- `ST_HOLD`: one recovery cycle with lockout only.

Its transitions are:
- RUN→FAIL and PINRST→FAIL, and HOLD→FAIL, when power fail is sampled high.
- RUN→PINRST when the synchronized pin is low and not ignored.
- PINRST→RUN when the pin is released or ignored.
- FAIL→HOLD on the first clock edge that samples power fail low.
- HOLD→RUN on the second consecutive such edge.

Top module: `ce_guard`

## Requirements
- R1: While `rst_n` is low, `abort` and `lockout` are 0. After reset the controller is in normal operation.
- R2: With `pwr_fail`=0 and `xfer_open`=0, `ce_out_n` equals `ce_in_n` in the same cycle, with no clocked delay.
- R3: With `pwr_fail`=0 and `xfer_open`=1, `ce_out_n` is 1 whatever `ce_in_n` is.
- R4: With `pwr_fail`=1 and `rom_mode`=0 (RAM attached), `ce_out_n` is 1 in the same cycle, regardless of `ce_in_n` and `xfer_open`.
- R5: With `pwr_fail`=1 and `rom_mode`=1 (ROM attached), `ce_out_n` is 0 in the same cycle, regardless of `ce_in_n` and `xfer_open`.
- R6: After any rising clock edge that samples `pwr_fail`=1, both `abort` and `lockout` are 1.
- R7: Once `pwr_fail` falls, `abort` clears after the first edge that samples it low. `lockout` clears only after the second consecutive edge that samples it low. If `pwr_fail` rises again in between, the sequence restarts from R6.
- R8: With `rst_ignore`=0, `abort` becomes 1 after the SYNC_STAGES+1-th rising edge that samples `rst_pin_n` low (the third edge for the default of 2). It stays 1 while the pin is held low and clears the same number of edges after the pin is released. `lockout` stays 0.
- R9: With `rst_ignore`=1, the reset pin has no effect: `abort` stays 0 while `rst_pin_n` is low.
- R10: Power fail takes priority over the reset pin. While both are active, `lockout` is 1. When power fail clears with the pin still held low, the controller passes through recovery (R7) before the pin abort is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ce_in_n | input | 1 | Host chip enable, active low |
| xfer_open | input | 1 | Serial register transfer window is open |
| pwr_fail | input | 1 | Digital power-fail indication, active high |
| rom_mode | input | 1 | 1 = ROM attached, 0 = RAM attached |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| rst_ignore | input | 1 | Reset-ignore register bit; 1 = reset pin ignored |
| ce_out_n | output | 1 | Chip enable to the external memory, active low |
| abort | output | 1 | Abort the serial transfer and clear the key pointer and counter |
| lockout | output | 1 | Block serial access until the supply has recovered |

## Verification
The hardest situation to reach is the recovery window. The bench must drop `pwr_fail` for exactly one clock and raise it again, so that the `ST_HOLD` to `ST_FAIL` path is taken and `lockout` is never seen to fall. It must also release `pwr_fail` while the reset pin is still held low, so that the pin abort appears only after recovery. The stimulus drives these glitches on exact cycles. A behavioural model counts consecutive low samples and keeps a two-deep history of the pin, and it predicts every output on every clock.

// File: rtl/ceg_pkg.sv
package ceg_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_PINRST = 2'd1,
        ST_FAIL   = 2'd2,
        ST_HOLD   = 2'd3
    } ceg_state_e;
endpackage

// File: rtl/ceg_sync.sv
module ceg_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain[0] <= d_async;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[gi] <= RESET_VAL;
                else        chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    assign q_sync = chain[MSB];
endmodule

// File: rtl/ceg_fsm.sv
module ceg_fsm
    import ceg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail,
    input  logic pin_low,
    input  logic rst_ignore,
    output logic abort,
    output logic lockout
);
    ceg_state_e state, nxt;
    logic pin_req;

    assign pin_req = pin_low && !rst_ignore;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:    if (pwr_fail) nxt = ST_FAIL;
                       else if (pin_req) nxt = ST_PINRST;
            ST_PINRST: if (pwr_fail) nxt = ST_FAIL;
                       else if (!pin_req) nxt = ST_RUN;
            ST_FAIL:   if (!pwr_fail) nxt = ST_HOLD;
            ST_HOLD:   if (pwr_fail) nxt = ST_FAIL;
                       else nxt = ST_RUN;
            default:   nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort   <= 1'b0;
            lockout <= 1'b0;
        end else begin
            abort   <= (nxt == ST_FAIL) || (nxt == ST_PINRST);
            lockout <= (nxt == ST_FAIL) || (nxt == ST_HOLD);
        end
    end
endmodule

// File: rtl/ceg_gate.sv
module ceg_gate (
    input  logic ce_in_n,
    input  logic xfer_open,
    input  logic pwr_fail,
    input  logic rom_mode,
    output logic ce_out_n
);
    always_comb begin
        if (pwr_fail)       ce_out_n = !rom_mode;
        else if (xfer_open) ce_out_n = 1'b1;
        else                ce_out_n = ce_in_n;
    end
endmodule

// File: rtl/ce_guard.sv
module ce_guard #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_in_n,
    input  logic xfer_open,
    input  logic pwr_fail,
    input  logic rom_mode,
    input  logic rst_pin_n,
    input  logic rst_ignore,
    output logic ce_out_n,
    output logic abort,
    output logic lockout
);
    logic pin_sync_n;

    ceg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rst_pin_n),
        .q_sync  (pin_sync_n)
    );

    ceg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_fail   (pwr_fail),
        .pin_low    (!pin_sync_n),
        .rst_ignore (rst_ignore),
        .abort      (abort),
        .lockout    (lockout)
    );

    ceg_gate u_gate (
        .ce_in_n   (ce_in_n),
        .xfer_open (xfer_open),
        .pwr_fail  (pwr_fail),
        .rom_mode  (rom_mode),
        .ce_out_n  (ce_out_n)
    );
endmodule

// File: rtl/ceg_chk.sv
module ceg_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_in_n,
    input logic xfer_open,
    input logic pwr_fail,
    input logic rom_mode,
    input logic ce_out_n,
    input logic abort,
    input logic lockout
);
    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_fail && !xfer_open) |-> (ce_out_n == ce_in_n));
    // R3
    window_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_fail && xfer_open) |-> ce_out_n);
    // R4
    ram_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && !rom_mode) |-> ce_out_n);
    // R5
    rom_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && rom_mode) |-> !ce_out_n);
    // R6
    fail_abort_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (abort && lockout));
    // R7
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lockout) |-> (!$past(pwr_fail) && !$past(pwr_fail, 2)));
endmodule

bind ce_guard ceg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_in_n   (ce_in_n),
    .xfer_open (xfer_open),
    .pwr_fail  (pwr_fail),
    .rom_mode  (rom_mode),
    .ce_out_n  (ce_out_n),
    .abort     (abort),
    .lockout   (lockout)
);

// File: tb/tb_ce_guard.sv
module tb_ce_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_in_n = 1'b1, xfer_open = 1'b0, pwr_fail = 1'b0, rom_mode = 1'b0;
    logic rst_pin_n = 1'b1, rst_ignore = 1'b0;
    logic ce_out_n, abort, lockout;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference state
    bit m_lock = 1'b0;
    bit m_abort = 1'b0;
    int m_low_cnt = 0;
    bit pin_h1 = 1'b1, pin_h2 = 1'b1;

    always #10 clk = ~clk;

    ce_guard dut (
        .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .xfer_open(xfer_open),
        .pwr_fail(pwr_fail), .rom_mode(rom_mode), .rst_pin_n(rst_pin_n),
        .rst_ignore(rst_ignore), .ce_out_n(ce_out_n), .abort(abort),
        .lockout(lockout)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lock = 0; m_abort = 0; m_low_cnt = 0; pin_h1 = 1; pin_h2 = 1;
        end else begin
            bit was_locked;
            was_locked = m_lock;
            if (pwr_fail) begin
                m_lock = 1; m_low_cnt = 0;
            end else if (m_lock) begin
                m_low_cnt++;
                if (m_low_cnt >= 2) m_lock = 0;
            end
            m_abort = pwr_fail || (!pin_h2 && !rst_ignore && !was_locked);
            pin_h2 = pin_h1;
            pin_h1 = rst_pin_n;
        end
    end

    function automatic bit exp_ce();
        if (pwr_fail) return !rom_mode;
        if (xfer_open) return 1'b1;
        return ce_in_n;
    endfunction

    task automatic chk(input string req, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit ce, input bit win, input bit pf, input bit rom,
                       input bit pin, input bit ign);
        @(negedge clk);
        ce_in_n = ce; xfer_open = win; pwr_fail = pf; rom_mode = rom;
        rst_pin_n = pin; rst_ignore = ign;
        #1;
        chk(cur_req, "ce_out_n", ce_out_n, exp_ce());
        chk(cur_req, "abort", abort, m_abort);
        chk(cur_req, "lockout", lockout, m_lock);
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        chk("R1", "abort in reset", abort, 1'b0);
        chk("R1", "lockout in reset", lockout, 1'b0);
        rst_n = 1'b1;
        cur_req = "R1";
        cyc(1, 0, 0, 0, 1, 0);
        // R2 pass-through
        cur_req = "R2";
        for (int i = 0; i < 6; i++) cyc(i[0], 0, 0, i[1], 1, 0);
        // R3 window
        cur_req = "R3";
        for (int i = 0; i < 4; i++) cyc(i[0], 1, 0, 0, 1, 0);
        // R4 RAM power fail, window open too; R6 abort/lockout
        cur_req = "R4";
        cyc(0, 1, 1, 0, 1, 0);
        cur_req = "R6";
        for (int i = 0; i < 3; i++) cyc(i[0], 0, 1, 0, 1, 0);
        chk("R6", "abort held", abort, 1'b1);
        chk("R6", "lockout held", lockout, 1'b1);
        // R7 one-cycle dip then re-assert
        cur_req = "R7";
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 1, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R7", "lockout after dip", lockout, 1'b1);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R7", "abort cleared first low", abort, 1'b0);
        chk("R7", "lockout still set", lockout, 1'b1);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R7", "lockout released", lockout, 1'b0);
        // R5 ROM power fail
        cur_req = "R5";
        for (int i = 0; i < 3; i++) cyc(i[0], i[1], 1, 1, 1, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 0);
        // R8 reset pin abort
        cur_req = "R8";
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 0);
        chk("R8", "pin abort", abort, 1'b1);
        chk("R8", "no lockout on pin", lockout, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 1, 0);
        chk("R8", "pin abort released", abort, 1'b0);
        // R9 pin ignored
        cur_req = "R9";
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 1);
        chk("R9", "pin ignored", abort, 1'b0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 1, 1);
        // R10 power fail with pin held low
        cur_req = "R10";
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, 0, 0);
        chk("R10", "lockout with pin", lockout, 1'b1);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0);
        chk("R10", "pin abort after recovery", abort, 1'b1);
        chk("R10", "lockout released", lockout, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 1, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule